// File: doc/BRIEF.md
# Pipelined Single-Precision Reciprocal Unit

This unit returns 1/x for a 32-bit IEEE-754 single-precision operand. It accepts a new operand on every clock and delivers each result a fixed six cycles later, in the order the operands arrived. A valid bit travels with each operand. There is no stall and no back-pressure.

The operand is first split with plain bit slicing. The sign and the biased exponent together form a 9-bit index into a 512-entry scale table. That table gives the result sign, the result exponent and the operand class. The top eight fraction bits index a 256-entry seed table. Each seed entry holds the reciprocal of the midpoint of its mantissa interval.

The seed is refined by two Newton-Raphson steps, each of the form x' = x*(2 - m*x). Here m is the full 24-bit mantissa with its hidden one restored. The refined mantissa reciprocal is then rounded to nearest and joined with the exponent from the scale table. Operands with a zero fraction skip the rounding path and give an exact power of two. Zero, denormal, infinite and NaN operands are handled by the scale table's class code.

Top module: `fp_recip_pipe`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly 6 clocks and is low after reset; results leave in arrival order.
- R2: An operand with biased exponent 0 (zero or denormal, flushed) yields infinity of the operand's sign: exponent field 0xFF, fraction 0.
- R3: An operand with exponent field 0xFF and fraction 0 (infinity) yields zero of the operand's sign.
- R4: An operand with exponent field 0xFF and nonzero fraction (NaN) yields the quiet NaN word 0x7FC00000.
- R5: A normal operand with fraction 0 whose reciprocal is normal yields exactly sign, biased exponent 254 - e, and fraction 0.
- R6: A normal operand with nonzero fraction whose exact reciprocal is at least 2^-126 yields a normal result within 1 ulp of the exact reciprocal.
- R7: A normal operand whose exact reciprocal magnitude is below 2^-126 yields zero of the operand's sign.
- R8: For every operand that is not NaN, bit 31 of the result equals bit 31 of the operand.
- R9: Operands presented on consecutive clocks, mixing special and normal classes, each produce their own correct result with no interaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the valid pipeline |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 32 | Single-precision reciprocal |

## Verification
Special-operand handling and the two-step mantissa refinement of a neighbouring normal operand occupy the same cycle when the two operands enter back to back. The stimulus therefore includes an unbroken burst of directed operands: zeros, denormals, infinities, NaNs, exact powers of two, underflow cases and ordinary values. That burst is followed by random operands that are mostly packed on adjacent clocks. Each result is matched in order to its own operand, and its arrival cycle is checked against the issue cycle. Each result is judged against a real-number reciprocal, or against the exact word for special and power-of-two cases.

// File: rtl/fp_recip_pipe.sv
module fp_recip_pipe #(
  parameter int FRAC_W = 32,
  parameter int SEED_F = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic [31:0] out_data
);
  localparam int MW   = 24;
  localparam int IDXW = 8;
  localparam int NSEED = 1 << IDXW;
  localparam int XW   = FRAC_W + 1;
  localparam int TW   = FRAC_W + 2;
  localparam int SW   = SEED_F + 1;
  localparam int PW   = MW + XW;
  localparam int QW   = XW + TW;
  localparam int LAT  = 6;
  localparam int SD   = 13;
  localparam logic [1:0] K_NORM = 2'd0, K_INF = 2'd1, K_ZERO = 2'd2, K_NAN = 2'd3;

  logic [SW-1:0] seed_rom [NSEED];
  for (genvar gi = 0; gi < NSEED; gi++) begin : g_seed
    localparam longint DEN = 2 * NSEED + 1 + 2 * gi;
    assign seed_rom[gi] = SW'(((64'd1 << (SEED_F + IDXW + 1)) + (DEN / 2)) / DEN);
  end

  function automatic logic [10:0] scale_lut(input logic [8:0] se);
    logic [1:0] k;
    logic [7:0] eb;
    k  = K_NORM;
    eb = 8'd254 - se[7:0];
    if (se[7:0] == 8'd0) k = K_INF;
    else if (se[7:0] == 8'hFF) k = K_ZERO;
    return {se[8], k, eb};
  endfunction

  function automatic logic [TW-1:0] scaled_prod(input logic [MW-1:0] m, input logic [XW-1:0] x);
    logic [PW-1:0] p;
    p = {{XW{1'b0}}, m} * {{MW{1'b0}}, x};
    return TW'(p >> (MW - 1));
  endfunction

  function automatic logic [XW-1:0] nr_refine(input logic [XW-1:0] x, input logic [TW-1:0] p);
    logic [TW-1:0] t;
    logic [QW-1:0] q;
    t = (TW'(1) << (FRAC_W + 1)) - p;
    q = {{TW{1'b0}}, x} * {{XW{1'b0}}, t};
    return XW'(q >> FRAC_W);
  endfunction

  logic [10:0] lut;
  logic        pow2;
  logic [1:0]  kind0;
  logic [7:0]  ex0;
  assign lut  = scale_lut(in_data[31:23]);
  assign pow2 = in_data[22:0] == 23'd0;

  always_comb begin
    ex0   = pow2 ? lut[7:0] : lut[7:0] - 8'd1;
    kind0 = lut[9:8];
    if (kind0 == K_NORM && (pow2 ? lut[7:0] == 8'd0 : lut[7:0] <= 8'd1)) kind0 = K_ZERO;
    if (in_data[30:23] == 8'hFF && !pow2) kind0 = K_NAN;
  end

  logic [SD-1:0] side_q [1:LAT-1];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i < LAT; i++) side_q[i] <= '0;
      out_valid <= 1'b0;
    end else begin
      side_q[1] <= {in_valid, lut[10], pow2, kind0, ex0};
      for (int i = 2; i < LAT; i++) side_q[i] <= side_q[i-1];
      out_valid <= side_q[LAT-1][SD-1];
    end
  end

  logic [MW-1:0] m1, m2, m3;
  logic [XW-1:0] x0_1, x0_2, x1_3, x1_4, x2_5;
  logic [TW-1:0] p1_2, p2_4;
  always_ff @(posedge clk) begin
    m1   <= {1'b1, in_data[22:0]};
    x0_1 <= {seed_rom[in_data[22:23-IDXW]], {(FRAC_W - SEED_F){1'b0}}};
    p1_2 <= scaled_prod(m1, x0_1);
    x0_2 <= x0_1;
    m2   <= m1;
    x1_3 <= nr_refine(x0_2, p1_2);
    m3   <= m2;
    p2_4 <= scaled_prod(m3, x1_3);
    x1_4 <= x1_3;
    x2_5 <= nr_refine(x1_4, p2_4);
  end

  logic [MW:0] top_bits, rnd;
  logic        s5, pw5;
  logic [1:0]  k5;
  logic [7:0]  e5;
  logic [31:0] res;
  assign {s5, pw5, k5, e5} = side_q[LAT-1][SD-2:0];
  assign top_bits = (MW + 1)'(x2_5 >> (FRAC_W - MW - 1));
  assign rnd      = {1'b0, top_bits[MW:1]} + (MW + 1)'(top_bits[0]);

  always_comb begin
    case (k5)
      K_INF:   res = {s5, 8'hFF, 23'd0};
      K_ZERO:  res = {s5, 31'd0};
      K_NAN:   res = 32'h7FC0_0000;
      default: begin
        if (pw5)         res = {s5, e5, 23'd0};
        else if (rnd[MW]) res = {s5, e5 + 8'd1, 23'd0};
        else             res = {s5, e5, rnd[MW-2:0]};
      end
    endcase
  end

  always_ff @(posedge clk) out_data <= res;

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##LAT out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##LAT !out_valid);
  a_r2_zero_to_inf: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data[30:23] == 8'd0) |-> ##LAT (out_valid && out_data[30:0] == 31'h7F80_0000));
  a_r3_inf_to_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data[30:0] == 31'h7F80_0000) |-> ##LAT (out_valid && out_data[30:0] == 31'd0));
  a_r4_nan_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data[30:23] == 8'hFF && in_data[22:0] != 23'd0) |-> ##LAT (out_data == 32'h7FC0_0000));
  a_r5_pow2_exact: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data[22:0] == 23'd0 && in_data[30:23] != 8'd0) |-> ##LAT (out_data[22:0] == 23'd0));
endmodule

// File: tb/fp_recip_pipe_tb.sv
module fp_recip_pipe_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = 32'd0;
  logic        out_valid;
  logic [31:0] out_data;

  fp_recip_pipe u_dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
                       .out_valid(out_valid), .out_data(out_data));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] q_op  [0:4095];
  int          q_cyc [0:4095];
  int sent = 0, rcv = 0, checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic real mag_of(input logic [31:0] w);
    return (1.0 + real'(w[22:0]) / 8388608.0) * (2.0 ** (real'(int'(w[30:23])) - 127.0));
  endfunction

  task automatic judge(input logic [31:0] a, input logic [31:0] y);
    logic [7:0] e;
    real ref_m, got_m, ulp;
    bit ok;
    e = a[30:23];
    if (e != 8'hFF || a[22:0] == 23'd0) check(y[31] == a[31], "R8 sign", y, {a[31], 31'd0});
    if (e == 8'd0) check(y == {a[31], 8'hFF, 23'd0}, "R2 zero/denormal", y, {a[31], 8'hFF, 23'd0});
    else if (e == 8'hFF && a[22:0] != 23'd0) check(y == 32'h7FC0_0000, "R4 nan", y, 32'h7FC0_0000);
    else if (e == 8'hFF) check(y == {a[31], 31'd0}, "R3 infinity", y, {a[31], 31'd0});
    else begin
      ref_m = 1.0 / mag_of(a);
      if (ref_m < 2.0 ** (-126.0)) check(y == {a[31], 31'd0}, "R7 underflow", y, {a[31], 31'd0});
      else if (a[22:0] == 23'd0) check(y == {a[31], 8'(254 - int'(e)), 23'd0}, "R5 pow2", y, {a[31], 8'(254 - int'(e)), 23'd0});
      else begin
        checks++;
        ok = y[30:23] != 8'd0 && y[30:23] != 8'hFF && y[31] == a[31];
        if (ok) begin
          got_m = mag_of(y);
          ulp = 2.0 ** (real'(int'(y[30:23])) - 150.0);
          ok = (got_m - ref_m <= ulp) && (ref_m - got_m <= ulp);
        end
        if (!ok) begin
          fails++;
          $display("FAIL R6 ulp for %h: got %h expected %e", a, y, ref_m);
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (rcv >= sent) check(1'b0, "R1 spurious valid", out_data, 32'd0);
      else begin
        check(cyc - q_cyc[rcv] == 6, "R1 latency", 32'(cyc - q_cyc[rcv]), 32'd6);
        judge(q_op[rcv], out_data);
        rcv++;
      end
    end
  end

  task automatic send(input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = a;
    q_op[sent]  = a;
    q_cyc[sent] = cyc;
    sent++;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = $urandom;
    end
  endtask

  function automatic logic [31:0] rand_op();
    logic [31:0] r;
    int pick;
    r = $urandom;
    pick = int'($urandom % 16);
    case (pick)
      0: r[30:23] = 8'd0;
      1: r[30:23] = 8'hFF;
      2: begin r[22:0] = 23'd0; r[30:23] = 8'(1 + $urandom % 254); end
      3: r[30:23] = 8'(250 + $urandom % 5);
      default: r[30:23] = 8'(1 + $urandom % 254);
    endcase
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got %0d results expected %0d", rcv, sent);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset", 32'(out_valid), 32'd0);
    rst = 1'b0;
    idle(2);
    // R9: directed burst, specials interleaved with normals on consecutive clocks
    send(32'h3F80_0000); send(32'h0000_0000); send(32'h4040_0000); send(32'h8000_0000);
    send(32'hC000_0000); send(32'h0000_0001); send(32'h3DCC_CCCD); send(32'h7F80_0000);
    send(32'h3FFF_FFFF); send(32'hFF80_0000); send(32'h00FF_FFFF); send(32'h7FC0_0001);
    send(32'h7F00_0000); send(32'h7E80_0001); send(32'h7E80_0000); send(32'h0080_0000);
    send(32'hBF80_0001); send(32'hFFFF_FFFF); send(32'h4120_0000); send(32'h7E7F_FFFF);
    idle(3);
    for (int i = 0; i < 3000; i++) begin
      send(rand_op());
      if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
    end
    idle(1);
    while (rcv < sent) @(negedge clk);
    idle(8);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule